// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register File

This block is a countdown watchdog that sits behind a small byte-addressed register file. Software programs a timeout in ticks, then writes the reload register to start a fresh count. An external strobe advances the count by one tick, where one tick stands for 0.6 s, so N seconds is N*10/6 ticks. Software reads the remaining count back from the reload register. When the count runs out, a timeout flag is raised and counting starts again from the programmed value.

If the count runs out a second time while that flag is still set, the block records a second timeout. If the no-reboot input is low, it also records a boot status flag and sends a one-cycle reset request to the platform. Two data registers give software a way to raise events: a byte write to either one sets its own status flag. The register file also holds two control registers, a pair of message bytes, a watchdog-count byte and a software-interrupt byte.

Register map (byte offsets; all registers little-endian): 0x00 timeout, 0x02 reload/remaining count, 0x04 status 1, 0x06 status 2, 0x08 control 1, 0x0A control 2, 0x0C data-in, 0x0D data-out, 0x0E message A, 0x0F message B, 0x10 watchdog-count byte, 0x11 software-interrupt byte. An access of size 0 is one byte, size 1 is two bytes and size 2 or 3 is four bytes, starting at the given offset. Reads have no side effects.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, timeout reads 0x0004, control 2 reads 0x0008, the software-interrupt byte reads 0x03, every other register reads 0, and rst_req is low.
- R2: The timeout field is 10 bits wide. Bits 15:10 written to offset 0x00 are dropped, so writing 0xFFFF reads back 0x03FF.
- R3: Any byte written within offsets 0x02–0x03 loads the counter with the timeout value. Offset 0x02 always reads the remaining count. A reload that arrives in the same cycle as a tick takes priority over the tick.
- R4: Each tick lowers the count by one. A tick that finds the count at 1 or 0 is an expiry: it sets status-1 bit 3 (0x0008) and reloads the count from the timeout. With 0x3FF loaded, the count reads 1 after 0x3FE ticks and no flag is set; the next tick sets the flag.
- R5: An expiry that occurs while status-1 bit 3 is set sets status-2 bit 1 (0x0002). If no_reboot is low, it also sets status-2 bit 2 (0x0004) and drives rst_req high for exactly one cycle.
- R6: While no_reboot is high, a second expiry raises neither rst_req nor status-2 bit 2.
- R7: Every status bit is cleared by writing 1 to it. Writing back the value just read returns the register to zero.
- R8: A byte write to data-in (0x0C) sets status-1 bit 1 (0x0002), and a byte write to data-out (0x0D) sets status-1 bit 2 (0x0004). The written values are stored and read back.
- R9: A 4-byte read at 0x04 returns status 2 in bits 31:16 and status 1 in bits 15:0. A 4-byte read at 0x08 packs control 2 over control 1 the same way. A 2-byte read at 0x0E returns message B over message A.
- R10: Control-1 bit 11 (0x0800) halts the count: ticks are ignored while it is set, and counting resumes when it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count strobe |
| no_reboot | input | 1 | High suppresses the reset request and boot status |
| reg_wr | input | 1 | Write strobe for the register access |
| reg_addr | input | 5 | Byte offset of the access |
| reg_size | input | 2 | Access size: 0 byte, 1 two bytes, 2 or 3 four bytes |
| reg_wdata | input | 32 | Write data, lane 0 at reg_addr |
| reg_rdata | output | 32 | Combinational read data for reg_addr and reg_size |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count shows up on the next read of offset 0x02. If the count is off, the timeout flag appears one or more ticks too early or too late, and a tick-by-tick walk exposes this at the first step that differs. A wrong status or reset-request state shows up in the cycle after the expiry tick: status 2 is wrong, or rst_req is missing, doubled or too wide. Packing and lane errors show up at once on the wide reads.

// File: rtl/wdog_pkg.sv
// Package: shared offsets, bit positions and access-size encoding for the
// two-stage watchdog. Assumes a 32-byte register window.
package wdog_pkg;
    // byte offsets
    localparam int OFF_TMO   = 'h00;
    localparam int OFF_RLD   = 'h02;
    localparam int OFF_STS1  = 'h04;
    localparam int OFF_STS2  = 'h06;
    localparam int OFF_CTL1  = 'h08;
    localparam int OFF_CTL2  = 'h0A;
    localparam int OFF_DIN   = 'h0C;
    localparam int OFF_DOUT  = 'h0D;
    localparam int OFF_MSGA  = 'h0E;
    localparam int OFF_MSGB  = 'h0F;
    localparam int OFF_WDC   = 'h10;
    localparam int OFF_SWI   = 'h11;

    // status and control bit positions
    localparam int S1_DIN_EVT  = 1;
    localparam int S1_DOUT_EVT = 2;
    localparam int S1_TIMEOUT  = 3;
    localparam int S2_SECOND   = 1;
    localparam int S2_BOOT     = 2;
    localparam int C1_HALT     = 11;

    // reset values
    localparam logic [15:0] TMO_RST  = 16'h0004;
    localparam logic [15:0] CTL2_RST = 16'h0008;
    localparam logic [7:0]  SWI_RST  = 8'h03;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WORD_ALT = 2'd3
    } acc_size_e;
endpackage

// File: rtl/wdog_regfile.sv
// Register file: splits each access into byte lanes, keeps the plain
// read/write registers, turns writes into reload/event/clear strobes, and
// forms the read data without delay. Assumes a 16-bit-or-less timeout field.
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int TMO_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    input  logic [TMO_W-1:0]  cnt,
    input  logic [15:0]       sts1,
    input  logic [15:0]       sts2,
    output logic [31:0]       reg_rdata,
    output logic [TMO_W-1:0]  tmo,
    output logic              halt,
    output logic              reload,
    output logic              din_wr,
    output logic              dout_wr,
    output logic [15:0]       sts1_clr,
    output logic [15:0]       sts2_clr
);
    localparam int NBYTES = 2 ** ADDR_W;
    localparam int LANES  = 4;

    logic [2:0]        n_bytes;
    logic [NBYTES-1:0] byte_we;
    logic [7:0]        byte_wd [NBYTES];
    logic [7:0]        rd_bytes [NBYTES];
    logic [15:0]       ctl1, ctl2;
    logic [7:0]        din_q, dout_q, msga, msgb, wdc, swi;
    logic [15:0]       tmo16, tmo_next;

    // merge a 16-bit register with its two write lanes
    function automatic logic [15:0] merge16(input logic [15:0] old,
                                            input logic we_lo, input logic [7:0] d_lo,
                                            input logic we_hi, input logic [7:0] d_hi);
        logic [15:0] r;
        r = old;
        if (we_lo) r[7:0]  = d_lo;
        if (we_hi) r[15:8] = d_hi;
        return r;
    endfunction

    // decode the access size into a byte count
    always_comb begin
        case (reg_size)
            SZ_BYTE: n_bytes = 3'd1;
            SZ_HALF: n_bytes = 3'd2;
            default: n_bytes = 3'd4;
        endcase
    end

    // scatter the write lanes onto per-byte enables and data
    always_comb begin
        byte_we = '0;
        for (int b = 0; b < NBYTES; b++) byte_wd[b] = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (reg_wr && (i < int'(n_bytes))) begin
                byte_we[reg_addr + ADDR_W'(i)] = 1'b1;
                byte_wd[reg_addr + ADDR_W'(i)] = reg_wdata[8*i +: 8];
            end
        end
    end

    assign tmo16    = {{(16-TMO_W){1'b0}}, tmo};
    assign tmo_next = merge16(tmo16, byte_we[OFF_TMO], byte_wd[OFF_TMO],
                              byte_we[OFF_TMO+1], byte_wd[OFF_TMO+1]);

    // plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo    <= TMO_RST[TMO_W-1:0];
            ctl1   <= 16'h0000;
            ctl2   <= CTL2_RST;
            din_q  <= 8'h00;
            dout_q <= 8'h00;
            msga   <= 8'h00;
            msgb   <= 8'h00;
            wdc    <= 8'h00;
            swi    <= SWI_RST;
        end else begin
            tmo  <= tmo_next[TMO_W-1:0];
            ctl1 <= merge16(ctl1, byte_we[OFF_CTL1], byte_wd[OFF_CTL1],
                            byte_we[OFF_CTL1+1], byte_wd[OFF_CTL1+1]);
            ctl2 <= merge16(ctl2, byte_we[OFF_CTL2], byte_wd[OFF_CTL2],
                            byte_we[OFF_CTL2+1], byte_wd[OFF_CTL2+1]);
            if (byte_we[OFF_DIN])  din_q  <= byte_wd[OFF_DIN];
            if (byte_we[OFF_DOUT]) dout_q <= byte_wd[OFF_DOUT];
            if (byte_we[OFF_MSGA]) msga   <= byte_wd[OFF_MSGA];
            if (byte_we[OFF_MSGB]) msgb   <= byte_wd[OFF_MSGB];
            if (byte_we[OFF_WDC])  wdc    <= byte_wd[OFF_WDC];
            if (byte_we[OFF_SWI])  swi    <= byte_wd[OFF_SWI];
        end
    end

    // strobes toward counter and status logic
    assign halt     = ctl1[C1_HALT];
    assign reload   = byte_we[OFF_RLD] | byte_we[OFF_RLD+1];
    assign din_wr   = byte_we[OFF_DIN];
    assign dout_wr  = byte_we[OFF_DOUT];
    assign sts1_clr = {byte_we[OFF_STS1+1] ? byte_wd[OFF_STS1+1] : 8'h00,
                       byte_we[OFF_STS1]   ? byte_wd[OFF_STS1]   : 8'h00};
    assign sts2_clr = {byte_we[OFF_STS2+1] ? byte_wd[OFF_STS2+1] : 8'h00,
                       byte_we[OFF_STS2]   ? byte_wd[OFF_STS2]   : 8'h00};

    // byte view of the register window for reads
    always_comb begin
        logic [15:0] cnt16;
        cnt16 = {{(16-TMO_W){1'b0}}, cnt};
        for (int b = 0; b < NBYTES; b++) rd_bytes[b] = 8'h00;
        rd_bytes[OFF_TMO]    = tmo16[7:0];
        rd_bytes[OFF_TMO+1]  = tmo16[15:8];
        rd_bytes[OFF_RLD]    = cnt16[7:0];
        rd_bytes[OFF_RLD+1]  = cnt16[15:8];
        rd_bytes[OFF_STS1]   = sts1[7:0];
        rd_bytes[OFF_STS1+1] = sts1[15:8];
        rd_bytes[OFF_STS2]   = sts2[7:0];
        rd_bytes[OFF_STS2+1] = sts2[15:8];
        rd_bytes[OFF_CTL1]   = ctl1[7:0];
        rd_bytes[OFF_CTL1+1] = ctl1[15:8];
        rd_bytes[OFF_CTL2]   = ctl2[7:0];
        rd_bytes[OFF_CTL2+1] = ctl2[15:8];
        rd_bytes[OFF_DIN]    = din_q;
        rd_bytes[OFF_DOUT]   = dout_q;
        rd_bytes[OFF_MSGA]   = msga;
        rd_bytes[OFF_MSGB]   = msgb;
        rd_bytes[OFF_WDC]    = wdc;
        rd_bytes[OFF_SWI]    = swi;
    end

    // gather the read lanes, masking those beyond the access size
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(n_bytes))
                reg_rdata[8*i +: 8] = rd_bytes[reg_addr + ADDR_W'(i)];
        end
    end
endmodule

// File: rtl/wdog_counter.sv
// Countdown: loads from the timeout on reload, steps down on each tick
// unless halted, and flags an expiry when a tick finds the count at 1 or 0,
// reloading in the same edge. Assumes tick is a one-cycle strobe.
module wdog_counter #(
    parameter int TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [TMO_W-1:0] tmo,
    output logic [TMO_W-1:0] cnt,
    output logic             expire
);
    logic step;

    // a tick that counts: not frozen and not overridden by a reload
    assign step   = tick && !halt && !reload;
    assign expire = step && (cnt <= TMO_W'(1));

    // count register update
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (reload)  cnt <= tmo;
        else if (expire)  cnt <= tmo;
        else if (step)    cnt <= cnt - TMO_W'(1);
    end

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !reload && cnt > TMO_W'(1)) |=> (cnt == TMO_W'($past(cnt) - 1)));

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(cnt));

    // R3
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt == $past(tmo)));
endmodule

// File: rtl/wdog_status.sv
// Status logic: keeps the two status registers with write-1-to-clear
// semantics (a set wins over a clear in the same cycle) and raises the
// one-cycle reset request on a second expiry when rebooting is allowed.
module wdog_status
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        expire,
    input  logic        no_reboot,
    input  logic        din_wr,
    input  logic        dout_wr,
    input  logic [15:0] sts1_clr,
    input  logic [15:0] sts2_clr,
    output logic [15:0] sts1,
    output logic [15:0] sts2,
    output logic        rst_req
);
    logic second;
    logic [15:0] s1_set, s2_set;

    // an expiry with the first-timeout flag still pending
    assign second = expire && sts1[S1_TIMEOUT];

    // set masks for this cycle
    always_comb begin
        s1_set = '0;
        s2_set = '0;
        s1_set[S1_TIMEOUT]  = expire;
        s1_set[S1_DIN_EVT]  = din_wr;
        s1_set[S1_DOUT_EVT] = dout_wr;
        s2_set[S2_SECOND]   = second;
        s2_set[S2_BOOT]     = second && !no_reboot;
    end

    // status registers and reset request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts1    <= '0;
            sts2    <= '0;
            rst_req <= 1'b0;
        end else begin
            sts1    <= (sts1 & ~sts1_clr) | s1_set;
            sts2    <= (sts2 & ~sts2_clr) | s2_set;
            rst_req <= second && !no_reboot;
        end
    end

    // R5
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(no_reboot));

    // R5
    second_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts2[S2_SECOND]) |-> $past(sts1[S1_TIMEOUT]));

    // R5
    boot_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts2[S2_BOOT]) |-> rst_req);
endmodule

// File: rtl/twostage_wdog.sv
// Top: two-stage watchdog with its register file. Assumes a synchronous
// register access (write taken on the clock edge, read combinational) and a
// tick strobe already synchronous to clk.
module twostage_wdog #(
    parameter int ADDR_W = 5,
    parameter int TMO_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              no_reboot,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rst_req
);
    logic [TMO_W-1:0] cnt, tmo;
    logic [15:0]      sts1, sts2, sts1_clr, sts2_clr;
    logic             halt, reload, din_wr, dout_wr, expire;

    wdog_regfile #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .cnt(cnt),
        .sts1(sts1), .sts2(sts2), .reg_rdata(reg_rdata), .tmo(tmo),
        .halt(halt), .reload(reload), .din_wr(din_wr), .dout_wr(dout_wr),
        .sts1_clr(sts1_clr), .sts2_clr(sts2_clr)
    );

    wdog_counter #(.TMO_W(TMO_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
        .reload(reload), .tmo(tmo), .cnt(cnt), .expire(expire)
    );

    wdog_status sts_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
        .din_wr(din_wr), .dout_wr(dout_wr), .sts1_clr(sts1_clr),
        .sts2_clr(sts2_clr), .sts1(sts1), .sts2(sts2), .rst_req(rst_req)
    );
endmodule

// File: tb/twostage_wdog_tb_top.sv
module twostage_wdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        no_reboot = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rst_req;

    int vectors = 0;
    int fails = 0;
    int req_cycles = 0;
    bit done = 1'b0;
    bit rd_pending = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    twostage_wdog dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .no_reboot(no_reboot),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size(reg_size),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rst_req(rst_req)
    );

    // monitor: pops expected read data and compares away from the edge
    always @(negedge clk) begin
        if (rst_n && rst_req) req_cycles++;
        if (rd_pending && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (reg_rdata !== e) begin
                fails++;
                $display("FAIL %s: read 0x%08h expected 0x%08h", t, reg_rdata, e);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string t);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [1:0] s, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        reg_addr = a; reg_size = s;
        exp_q.push_back(e); tag_q.push_back(t);
        rd_pending = 1'b1;
        @(negedge clk); #1;
        rd_pending = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values, R9 packing
        rd(5'h00, 2'd1, 32'h0004, "R1 timeout");
        rd(5'h02, 2'd1, 32'h0000, "R1 reload");
        rd(5'h04, 2'd2, 32'h0000_0000, "R1 status pair");
        rd(5'h08, 2'd2, 32'h0008_0000, "R1 R9 control pair");
        rd(5'h0C, 2'd1, 32'h0000, "R1 data pair");
        rd(5'h0E, 2'd1, 32'h0000, "R1 message pair");
        rd(5'h10, 2'd0, 32'h00, "R1 wd count byte");
        rd(5'h11, 2'd0, 32'h03, "R1 swirq byte");
        chk(rst_req, 0, "R1 rst_req low");

        // R2 timeout width
        wr(5'h00, 2'd1, 32'hFFFF);
        rd(5'h00, 2'd1, 32'h03FF, "R2 timeout masked");

        // R3 R4 max timeout
        wr(5'h02, 2'd1, 32'h0004);
        rd(5'h02, 2'd1, 32'h03FF, "R3 reload loads timeout");
        ticks(32'h3FE);
        rd(5'h02, 2'd1, 32'h0001, "R4 count at one");
        rd(5'h04, 2'd1, 32'h0000, "R4 no flag yet");
        ticks(1);
        rd(5'h04, 2'd1, 32'h0008, "R4 first expiry flag");
        rd(5'h02, 2'd1, 32'h03FF, "R4 restart from timeout");

        // R7 clear by writing back
        wr(5'h04, 2'd1, 32'h0008);
        rd(5'h04, 2'd1, 32'h0000, "R7 status 1 cleared");

        // R4 tick-by-tick walk from 13 (8 s)
        wr(5'h00, 2'd1, 32'd13);
        wr(5'h02, 2'd0, 32'h00);
        for (int i = 0; i < 13; i++) begin
            rd(5'h02, 2'd1, 32'(13 - i), "R4 remaining count");
            rd(5'h04, 2'd1, 32'h0000, "R4 no early flag");
            ticks(1);
        end
        rd(5'h04, 2'd1, 32'h0008, "R4 flag after walk");

        // R6 second expiry with reboot inhibited
        wr(5'h00, 2'd1, 32'd3);
        wr(5'h02, 2'd1, 32'h0);
        ticks(3);
        rd(5'h06, 2'd1, 32'h0002, "R6 second flag, no boot flag");
        chk(req_cycles, 0, "R6 no reset request");

        // R7 R9 clear both via 4-byte write
        wr(5'h04, 2'd2, 32'h0002_0008);
        rd(5'h04, 2'd2, 32'h0000_0000, "R7 both status cleared");

        // R5 second expiry with reboot allowed
        no_reboot = 1'b0;
        wr(5'h02, 2'd1, 32'h0);
        ticks(3);
        rd(5'h04, 2'd2, 32'h0000_0008, "R5 first expiry only");
        chk(req_cycles, 0, "R5 no request on first expiry");
        ticks(3);
        rd(5'h04, 2'd2, 32'h0006_0008, "R5 R9 second and boot flags");
        chk(req_cycles, 1, "R5 one-cycle reset request");
        wr(5'h04, 2'd2, 32'h0006_0008);
        rd(5'h04, 2'd2, 32'h0000_0000, "R7 write back clears");
        no_reboot = 1'b1;

        // R8 data register events
        wr(5'h0C, 2'd0, 32'h5A);
        rd(5'h04, 2'd1, 32'h0002, "R8 data-in event");
        wr(5'h0D, 2'd0, 32'hA5);
        rd(5'h04, 2'd1, 32'h0006, "R8 data-out event");
        rd(5'h0C, 2'd1, 32'hA55A, "R8 data values stored");
        wr(5'h04, 2'd1, 32'h0006);
        rd(5'h04, 2'd1, 32'h0000, "R7 event flags cleared");

        // R10 halt
        wr(5'h08, 2'd1, 32'h0800);
        wr(5'h02, 2'd1, 32'h0);
        ticks(5);
        rd(5'h02, 2'd1, 32'd3, "R10 count frozen");
        rd(5'h04, 2'd1, 32'h0000, "R10 no expiry while halted");
        wr(5'h08, 2'd1, 32'h0000);
        ticks(1);
        rd(5'h02, 2'd1, 32'd2, "R10 resumes");

        // R3 reload wins over a simultaneous tick
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 5'h02; reg_size = 2'd1; reg_wdata = 32'h0; tick = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; tick = 1'b0;
        rd(5'h02, 2'd1, 32'd3, "R3 reload beats tick");

        // R9 message pair and wider window
        wr(5'h0E, 2'd1, 32'hBEEF);
        rd(5'h0E, 2'd1, 32'hBEEF, "R9 message pair");
        rd(5'h0E, 2'd2, 32'h0300_BEEF, "R9 message with following bytes");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule